// File: doc/BRIEF.md
# Per-Sample In-Flight Write Scoreboard

This block keeps pixel-shader work in the correct order when shaders are allowed to read the render-target location they are about to write. A small screen region is split into quads of 2x2 pixels, and every pixel holds several samples. The block stores one busy bit for every sample that an in-flight quad will write. A new quad is offered with its quad coordinate and a coverage mask. It is granted in the same cycle only if none of its covered samples is still busy. On grant, its samples are marked busy, so marking always happens together with issue.

A quad that has finished shading reports back on a completion port with its coordinate and mask. That clears exactly those bits. When a completion and a request name the same quad in the same cycle, the completion counts first. Busy state is kept per sample, so two triangles that share an edge quad but cover different samples can be in flight together. The table covers every sample of the region, so nothing ever overflows and nothing is dropped.

The request port has a single holder. A stalled request keeps its grant low, and no later quad can pass it. This keeps the original submission order.

Top module: `sample_scoreboard`

## Requirements
- R1: After reset every busy bit is clear, so a request with any coverage mask to any quad is granted.
- R2: `req_grant` is high in the same cycle as `req_valid` exactly when the request mask ANDed with that quad's busy bits is zero. Quad index = qy*8+qx. Mask bit = pixel*4+sample, with pixel = py*2+px inside the quad.
- R3: A granted request sets its mask bits busy from the next cycle on. A repeat of the same samples is then refused.
- R4: While a request is refused, `req_conflict` shows exactly the overlapping busy bits. `req_conflict` is zero when `req_valid` is low.
- R5: Requests to the same quad with disjoint sample masks are both granted and both stay in flight.
- R6: A completion clears exactly its mask bits in its quad from the next cycle on. Other bits keep their state.
- R7: A completion and a request to the same quad in the same cycle: the cleared bits do not count as a conflict for that request.
- R8: Busy bits of one quad never affect the grant of another quad.
- R9: All samples of all 64 quads can be busy at once, and each keeps blocking until it is cleared.
- R10: With `req_valid` low, `req_grant` stays low and no bit is marked busy.
- R11: A refused request stays refused every cycle until a completion removes the overlap. It is granted in the cycle that completion takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Quad waiting to issue |
| req_qx | input | 3 | Quad column |
| req_qy | input | 3 | Quad row |
| req_mask | input | 16 | Sample coverage of the quad |
| req_grant | output | 1 | Quad may issue now; its samples become busy |
| req_conflict | output | 16 | Covered samples that are still busy |
| cmp_valid | input | 1 | A quad finished shading |
| cmp_qx | input | 3 | Column of the finished quad |
| cmp_qy | input | 3 | Row of the finished quad |
| cmp_mask | input | 16 | Samples released by the finished quad |

## Verification
A stuck or missing busy bit shows up at the ports in the very next cycle that touches that quad. A lost set lets a repeat request be granted when it should be refused. A lost clear keeps a request refused after its completion. A clear that spills into another quad or onto other samples shows up as a wrong `req_conflict` bit. Ordering the completion after the conflict check shows only in a same-cycle, same-quad collision, so that case is driven on purpose as well as by random traffic. A full-table fill shows whether any entry is missing.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int QUADS_X   = 8;
    localparam int QUADS_Y   = 8;
    localparam int PIX_QUAD  = 4;
    localparam int SAMPLES   = 4;
    localparam int MASK_W    = PIX_QUAD * SAMPLES;
    localparam int QUADS     = QUADS_X * QUADS_Y;
    localparam int XW        = $clog2(QUADS_X);
    localparam int YW        = $clog2(QUADS_Y);
    localparam int IW        = $clog2(QUADS);

    typedef logic [MASK_W-1:0] cov_t;
    typedef logic [IW-1:0]     qidx_t;

    typedef struct packed {
        logic [YW-1:0] qy;
        logic [XW-1:0] qx;
    } qpos_t;

    typedef struct packed {
        logic  vld;
        qidx_t idx;
        cov_t  mask;
    } qop_t;

    function automatic qidx_t quad_idx(input qpos_t p);
        return qidx_t'(p.qy) * qidx_t'(QUADS_X) + qidx_t'(p.qx);
    endfunction
endpackage

// File: rtl/scb_busy_table.sv
module scb_busy_table
    import scb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  qop_t  set_op,
    input  qop_t  clr_op,
    input  qidx_t rd_idx,
    output cov_t  rd_busy,
    output logic [QUADS*MASK_W-1:0] busy_flat
);
    cov_t entry [QUADS];

    for (genvar g = 0; g < QUADS; g++) begin : g_entry
        cov_t set_m;
        cov_t clr_m;
        always_comb begin
            set_m = (set_op.vld && set_op.idx == qidx_t'(g)) ? set_op.mask : '0;
            clr_m = (clr_op.vld && clr_op.idx == qidx_t'(g)) ? clr_op.mask : '0;
        end
        always_ff @(posedge clk) begin
            if (rst) entry[g] <= '0;
            else     entry[g] <= (entry[g] & ~clr_m) | set_m;
        end
        assign busy_flat[g*MASK_W +: MASK_W] = entry[g];
    end

    assign rd_busy = entry[rd_idx];
endmodule

// File: rtl/scb_conflict.sv
module scb_conflict
    import scb_pkg::*;
(
    input  qop_t req_op,
    input  qop_t cmp_op,
    input  cov_t stored,
    output cov_t conflict,
    output logic grant
);
    cov_t released;
    cov_t still_busy;

    always_comb begin
        released   = (cmp_op.vld && cmp_op.idx == req_op.idx) ? cmp_op.mask : '0;
        still_busy = stored & ~released;
        conflict   = req_op.vld ? (req_op.mask & still_busy) : '0;
        grant      = req_op.vld && (conflict == '0);
    end
endmodule

// File: rtl/sample_scoreboard.sv
module sample_scoreboard
    import scb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [XW-1:0]     req_qx,
    input  logic [YW-1:0]     req_qy,
    input  logic [MASK_W-1:0] req_mask,
    output logic              req_grant,
    output logic [MASK_W-1:0] req_conflict,
    input  logic              cmp_valid,
    input  logic [XW-1:0]     cmp_qx,
    input  logic [YW-1:0]     cmp_qy,
    input  logic [MASK_W-1:0] cmp_mask
);
    qop_t req_op;
    qop_t cmp_op;
    qop_t set_op;
    cov_t stored;
    logic grant_w;
    logic [QUADS*MASK_W-1:0] busy_flat;

    always_comb begin
        req_op.vld  = req_valid;
        req_op.idx  = quad_idx('{qy: req_qy, qx: req_qx});
        req_op.mask = req_mask;
        cmp_op.vld  = cmp_valid;
        cmp_op.idx  = quad_idx('{qy: cmp_qy, qx: cmp_qx});
        cmp_op.mask = cmp_mask;
        set_op      = req_op;
        set_op.vld  = grant_w;
    end

    scb_busy_table u_table (
        .clk      (clk),
        .rst      (rst),
        .set_op   (set_op),
        .clr_op   (cmp_op),
        .rd_idx   (req_op.idx),
        .rd_busy  (stored),
        .busy_flat(busy_flat)
    );

    scb_conflict u_conflict (
        .req_op  (req_op),
        .cmp_op  (cmp_op),
        .stored  (stored),
        .conflict(req_conflict),
        .grant   (grant_w)
    );

    assign req_grant = grant_w;
endmodule

// File: rtl/scb_checker.sv
module scb_checker
    import scb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [XW-1:0]     req_qx,
    input logic [YW-1:0]     req_qy,
    input logic [MASK_W-1:0] req_mask,
    input logic              req_grant,
    input logic [MASK_W-1:0] req_conflict,
    input logic              cmp_valid,
    input logic [XW-1:0]     cmp_qx,
    input logic [YW-1:0]     cmp_qy,
    input logic [MASK_W-1:0] cmp_mask,
    input logic [QUADS*MASK_W-1:0] busy_flat
);
    function automatic cov_t word_of(input logic [QUADS*MASK_W-1:0] f, input qidx_t i);
        return f[i*MASK_W +: MASK_W];
    endfunction

    qidx_t ridx;
    qidx_t cidx;
    assign ridx = quad_idx('{qy: req_qy, qx: req_qx});
    assign cidx = quad_idx('{qy: cmp_qy, qx: cmp_qx});

    // R1: table empty right after reset
    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> busy_flat == '0);

    // R3: granted samples are busy in the following cycle
    assert_marked_on_grant_R3: assert property (@(posedge clk) disable iff (rst)
        req_grant |=> (word_of(busy_flat, $past(ridx)) & $past(req_mask)) == $past(req_mask));

    // R4: a refusal always names at least one busy sample
    assert_refusal_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_grant) |-> req_conflict != '0);

    // R6: a completion not overlapped by a same-quad grant leaves its bits clear
    assert_cleared_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !(req_grant && ridx == cidx)) |=>
            (word_of(busy_flat, $past(cidx)) & $past(cmp_mask)) == '0);

    // R10: no grant without a request, and no change in busy state from an idle cycle without completion
    assert_no_grant_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !req_grant);
    assert_idle_keeps_table_R10: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !cmp_valid) |=> $stable(busy_flat));
endmodule

bind sample_scoreboard scb_checker u_scb_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_qx      (req_qx),
    .req_qy      (req_qy),
    .req_mask    (req_mask),
    .req_grant   (req_grant),
    .req_conflict(req_conflict),
    .cmp_valid   (cmp_valid),
    .cmp_qx      (cmp_qx),
    .cmp_qy      (cmp_qy),
    .cmp_mask    (cmp_mask),
    .busy_flat   (busy_flat)
);

// File: tb/test_sample_scoreboard.sv
module test_sample_scoreboard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_qx = '0;
    logic [2:0]  req_qy = '0;
    logic [15:0] req_mask = '0;
    logic        req_grant;
    logic [15:0] req_conflict;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_qx = '0;
    logic [2:0]  cmp_qy = '0;
    logic [15:0] cmp_mask = '0;

    int checks = 0;
    int errors = 0;
    logic [15:0] mdl [64];

    always #5 clk = ~clk;

    sample_scoreboard i_sample_scoreboard (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_qx(req_qx), .req_qy(req_qy), .req_mask(req_mask),
        .req_grant(req_grant), .req_conflict(req_conflict),
        .cmp_valid(cmp_valid), .cmp_qx(cmp_qx), .cmp_qy(cmp_qy), .cmp_mask(cmp_mask)
    );

    function automatic int qi(input logic [2:0] x, input logic [2:0] y);
        return int'(y) * 8 + int'(x);
    endfunction

    function automatic logic [15:0] exp_conflict(input logic v, input logic [2:0] x, input logic [2:0] y,
                                                 input logic [15:0] m, input logic cv,
                                                 input logic [2:0] cx, input logic [2:0] cy,
                                                 input logic [15:0] cm);
        logic [15:0] rel;
        rel = (cv && qi(cx, cy) == qi(x, y)) ? cm : 16'h0;
        return v ? (m & mdl[qi(x, y)] & ~rel) : 16'h0;
    endfunction

    task automatic step(input logic v, input logic [2:0] x, input logic [2:0] y, input logic [15:0] m,
                        input logic cv, input logic [2:0] cx, input logic [2:0] cy, input logic [15:0] cm,
                        input string tag);
        logic [15:0] ec;
        logic eg;
        @(negedge clk);
        req_valid = v; req_qx = x; req_qy = y; req_mask = m;
        cmp_valid = cv; cmp_qx = cx; cmp_qy = cy; cmp_mask = cm;
        #1;
        ec = exp_conflict(v, x, y, m, cv, cx, cy, cm);
        eg = v && (ec == 16'h0);
        checks++;
        if (req_grant !== eg || req_conflict !== ec) begin
            errors++;
            $display("FAIL %s grant=%0b conflict=%h expected grant=%0b conflict=%h",
                     tag, req_grant, req_conflict, eg, ec);
        end
        if (cv) mdl[qi(cx, cy)] = mdl[qi(cx, cy)] & ~cm;
        if (eg) mdl[qi(x, y)] = mdl[qi(x, y)] | m;
    endtask

    task automatic req(input logic [2:0] x, input logic [2:0] y, input logic [15:0] m, input string tag);
        step(1'b1, x, y, m, 1'b0, 3'd0, 3'd0, 16'h0, tag);
    endtask

    task automatic done(input logic [2:0] x, input logic [2:0] y, input logic [15:0] m, input string tag);
        step(1'b0, 3'd0, 3'd0, 16'h0, 1'b1, x, y, m, tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 64; i++) mdl[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10: idle cycle, nothing granted or marked
        step(1'b0, 3'd2, 3'd2, 16'hFFFF, 1'b0, 3'd0, 3'd0, 16'h0, "R10 idle");
        // R1: fresh table grants full masks
        req(3'd0, 3'd0, 16'hFFFF, "R1 empty quad0");
        req(3'd7, 3'd7, 16'hFFFF, "R1 empty quad63");
        // R3 / R4: repeat refused with full conflict
        req(3'd0, 3'd0, 16'hFFFF, "R3 repeat refused");
        req(3'd0, 3'd0, 16'h0010, "R4 single sample conflict");
        // R6: partial clear
        done(3'd0, 3'd0, 16'h00FF, "R6 partial clear");
        req(3'd0, 3'd0, 16'hFFFF, "R6 remaining bits conflict");
        req(3'd0, 3'd0, 16'h0081, "R6 cleared bits granted");
        // R11: stall persists, then grant when cleared
        req(3'd0, 3'd0, 16'h0100, "R11 stall cycle 1");
        req(3'd0, 3'd0, 16'h0100, "R11 stall cycle 2");
        // R7: same-cycle completion and request
        step(1'b1, 3'd0, 3'd0, 16'h0100, 1'b1, 3'd0, 3'd0, 16'h0100, "R7 clear before check");
        // R5: disjoint samples, same quad
        req(3'd5, 3'd1, 16'h000F, "R5 first pixel");
        req(3'd5, 3'd1, 16'h00F0, "R5 second pixel");
        req(3'd5, 3'd1, 16'h0008, "R5 overlap refused");
        req(3'd5, 3'd1, 16'h1100, "R5 other samples granted");
        // R8: neighbouring quad unaffected
        req(3'd6, 3'd1, 16'hFFFF, "R8 neighbour quad");
        // R9: fill the whole table
        for (int q = 0; q < 64; q++) done(3'(q % 8), 3'(q / 8), 16'hFFFF, "R9 drain");
        for (int q = 0; q < 64; q++) req(3'(q % 8), 3'(q / 8), 16'hFFFF, "R9 fill");
        for (int q = 0; q < 64; q++) req(3'(q % 8), 3'(q / 8), 16'(1 << (q % 16)), "R9 all blocking");
        for (int q = 0; q < 64; q++) done(3'(q % 8), 3'(q / 8), 16'hFFFF, "R9 release");
        req(3'd3, 3'd4, 16'hFFFF, "R9 granted after release");
        // Random traffic, focused on a few quads to create collisions
        for (int n = 0; n < 4000; n++) begin
            logic v, cv;
            logic [2:0] x, y, cx, cy;
            logic [15:0] m, cm;
            v  = ($urandom % 4) != 0;
            cv = ($urandom % 3) == 0;
            x  = 3'($urandom % 3); y = 3'($urandom % 2);
            cx = ($urandom % 2) ? x : 3'($urandom % 3);
            cy = ($urandom % 2) ? y : 3'($urandom % 2);
            m  = 16'(1 << ($urandom % 16)) | (($urandom % 2) ? 16'($urandom) & 16'($urandom) : 16'h0);
            cm = 16'($urandom);
            step(v, x, y, m, cv, cx, cy, cm, "R2 random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule